// File: doc/BRIEF.md
# GPIO Edge Interrupt Status Unit

This unit watches a group of 31 general-purpose input pins and latches their edges into two pending-event registers. One register collects assert events and the other collects deassert events. A per-pin polarity bit picks which edge is the assert edge, and the opposite edge is the deassert edge. Each register drives its own interrupt line. A line is high while at least one pending bit of its register belongs to a pin whose enable bit is set.

Software writes the pending registers through a simple register port. Bit 0 of the write word selects the action. When bit 0 is 1, every 1 in bits 1 to 31 sets the pending bit for the matching pin. When bit 0 is 0, every 1 in those bits clears it. Bits written as 0 leave their pending bits unchanged. This lets software acknowledge or inject any set of events in a single write without a read-modify-write sequence. Each pin passes through a two-stage synchronizer and then an edge register before event detection.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every register reads 0 and both interrupt outputs are 0.
- R2: Pin n is held in bit n+1 of both pending registers, and bit 0 of a pending-register read is always 0. A pending bit changes only through a write or a new event.
- R3: With polarity bit 1, a rising edge on a pin sets its assert pending bit and a falling edge sets its deassert pending bit.
- R4: With polarity bit 0, a falling edge sets the assert pending bit and a rising edge sets the deassert pending bit. One edge never sets both registers.
- R5: A pending-register write with bit 0 at 0 clears every pending bit whose data bit is 1 and leaves the other pending bits unchanged.
- R6: A pending-register write with bit 0 at 1 sets every pending bit whose data bit is 1 and leaves the other pending bits unchanged.
- R7: irq_assert_o is 1 exactly when some assert pending bit for pin n is set while enable bit n is 1. irq_deassert_o follows the same rule for the deassert register. Events latch whether or not the pin is enabled.
- R8: If an edge event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R9: A pin change that is driven before a rising clock edge first shows in the pending register after the third rising edge, counting that edge as the first.
- R10: The enable and polarity registers read back as written, with pin n in bit n and bit 31 reading 0. Register select encoding for wr_sel_i and rd_sel_i: 0 is enable, 1 is polarity, 2 is assert pending, 3 is deassert pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 31 | Asynchronous GPIO inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target register select |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read register select |
| rd_data_o | output | 32 | Combinational read data |
| irq_assert_o | output | 1 | Interrupt for enabled assert pending events |
| irq_deassert_o | output | 1 | Interrupt for enabled deassert pending events |

## Verification
The bench targets the one-bit shift between pin index and pending-bit index. A design without the shift would report events on the wrong pin, or would let bit 0 read back as set. It aligns an edge event with a clearing write on the same bit, which a write-priority design would lose. It checks both polarity settings, where swapping the edge roles would fill the wrong register. It also tracks the exact three-edge latency, which an extra or missing stage would shift. It toggles enables while events are pending, so a line that ignores the enable, or uses the wrong bit of it, would drive a wrong interrupt level.

// File: rtl/gpio_edge_irq_pkg.sv
package gpio_edge_irq_pkg;
  typedef enum logic [1:0] {
    SEL_ENABLE   = 2'd0,
    SEL_POLARITY = 2'd1,
    SEL_ASSERT   = 2'd2,
    SEL_DEASSERT = 2'd3
  } gei_sel_e;
endpackage

// File: rtl/gpio_edge_sampler.sv
module gpio_edge_sampler #(
  parameter int NPINS       = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic [NPINS-1:0] pol_i,
  output logic [NPINS-1:0] ast_evt_o,
  output logic [NPINS-1:0] dea_evt_o
);
  logic [SYNC_STAGES-1:0][NPINS-1:0] sync_q, sync_d;
  logic [NPINS-1:0] prev_q, cur, rise, fall;

  always_comb begin
    sync_d[0] = pins_i;
    for (int i = 1; i < SYNC_STAGES; i++) sync_d[i] = sync_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= cur;
    end
  end

  assign cur       = sync_q[SYNC_STAGES-1];
  assign rise      = cur & ~prev_q;
  assign fall      = ~cur & prev_q;
  assign ast_evt_o = (pol_i & rise) | (~pol_i & fall);
  assign dea_evt_o = (pol_i & fall) | (~pol_i & rise);
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int NPINS = 31,
  localparam int REG_W = NPINS + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] evt_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [NPINS-1:0] st_o
);
  logic [NPINS-1:0] st_q, st_d, mask;
  logic             upd;

  assign mask = wr_data_i[REG_W-1:1];
  assign upd  = wr_i | (|evt_i);

  always_comb begin
    st_d = st_q;
    if (wr_i) begin
      if (wr_data_i[0]) st_d = st_q | mask;
      else              st_d = st_q & ~mask;
    end
    st_d = st_d | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= '0;
    else if (upd) st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_irq_pkg::*;
#(
  parameter int NPINS       = 31,
  parameter int SYNC_STAGES = 2,
  localparam int REG_W      = NPINS + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [1:0]       rd_sel_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_assert_o,
  output logic             irq_deassert_o
);
  logic             rst_meta_q, rst_int_n;
  logic [NPINS-1:0] en_q, pol_q, en_d, pol_d;
  logic [NPINS-1:0] ast_evt, dea_evt, ast_st, dea_st;
  logic             wr_en_reg, wr_pol, wr_ast, wr_dea;
  gei_sel_e         wsel, rsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  assign wsel      = gei_sel_e'(wr_sel_i);
  assign rsel      = gei_sel_e'(rd_sel_i);
  assign wr_en_reg = wr_en_i && (wsel == SEL_ENABLE);
  assign wr_pol    = wr_en_i && (wsel == SEL_POLARITY);
  assign wr_ast    = wr_en_i && (wsel == SEL_ASSERT);
  assign wr_dea    = wr_en_i && (wsel == SEL_DEASSERT);
  assign en_d      = wr_data_i[NPINS-1:0];
  assign pol_d     = wr_data_i[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q  <= '0;
      pol_q <= '0;
    end else begin
      if (wr_en_reg) en_q  <= en_d;
      if (wr_pol)    pol_q <= pol_d;
    end
  end

  gpio_edge_sampler #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_int_n), .pins_i(pins_i), .pol_i(pol_q),
    .ast_evt_o(ast_evt), .dea_evt_o(dea_evt)
  );

  gpio_evt_status #(.NPINS(NPINS)) u_ast (
    .clk(clk), .rst_n(rst_int_n), .evt_i(ast_evt), .wr_i(wr_ast),
    .wr_data_i(wr_data_i), .st_o(ast_st)
  );

  gpio_evt_status #(.NPINS(NPINS)) u_dea (
    .clk(clk), .rst_n(rst_int_n), .evt_i(dea_evt), .wr_i(wr_dea),
    .wr_data_i(wr_data_i), .st_o(dea_st)
  );

  always_comb begin
    unique case (rsel)
      SEL_ENABLE:   rd_data_o = {1'b0, en_q};
      SEL_POLARITY: rd_data_o = {1'b0, pol_q};
      SEL_ASSERT:   rd_data_o = {ast_st, 1'b0};
      default:      rd_data_o = {dea_st, 1'b0};
    endcase
  end

  assign irq_assert_o   = |(ast_st & en_q);
  assign irq_deassert_o = |(dea_st & en_q);
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int NPINS = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_ast,
  input logic [NPINS:0]   wr_data,
  input logic [NPINS-1:0] ast_evt,
  input logic [NPINS-1:0] dea_evt,
  input logic [NPINS-1:0] ast_st,
  input logic             irq_a
);
  // R8
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ast_evt != '0) |=> ((ast_st & $past(ast_evt)) == $past(ast_evt)));
  // R5
  clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ast && !wr_data[0] && ast_evt == '0) |=> ((ast_st & $past(wr_data[NPINS:1])) == '0));
  // R6
  set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ast && wr_data[0]) |=> ((ast_st & $past(wr_data[NPINS:1])) == $past(wr_data[NPINS:1])));
  // R4
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ast_evt & dea_evt) == '0));
  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> (ast_st != '0));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ast && ast_evt == '0) |=> $stable(ast_st));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .wr_ast(wr_ast), .wr_data(wr_data_i),
  .ast_evt(ast_evt), .dea_evt(dea_evt), .ast_st(ast_st), .irq_a(irq_assert_o)
);

// File: tb/gpio_edge_irq_bench.sv
module gpio_edge_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 31;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [NP:0]   wr_data = '0;
  logic [1:0]    rd_sel = '0;
  logic [NP:0]   rd_data;
  logic          irq_a, irq_d;
  int            errors = 0;
  int            checks = 0;

  logic [NP-1:0] m_en = '0, m_pol = '0, m_ast = '0, m_dea = '0;
  logic [NP-1:0] hist[$];

  gpio_edge_irq u_gpio_edge_irq (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .irq_assert_o(irq_a), .irq_deassert_o(irq_d)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    logic [NP-1:0] cur, prv, rise, fall, aev, dev;
    if (!rst_n) begin
      m_en = '0; m_pol = '0; m_ast = '0; m_dea = '0;
      hist = {'0, '0, '0};
    end else begin
      cur = hist[1]; prv = hist[2];
      rise = cur & ~prv; fall = ~cur & prv;
      aev = (m_pol & rise) | (~m_pol & fall);
      dev = (m_pol & fall) | (~m_pol & rise);
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_en  = wr_data[NP-1:0];
          2'd1: m_pol = wr_data[NP-1:0];
          2'd2: m_ast = wr_data[0] ? (m_ast | wr_data[NP:1]) : (m_ast & ~wr_data[NP:1]);
          default: m_dea = wr_data[0] ? (m_dea | wr_data[NP:1]) : (m_dea & ~wr_data[NP:1]);
        endcase
      end
      m_ast = m_ast | aev;
      m_dea = m_dea | dev;
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  function automatic logic [NP:0] model_rd(input int s);
    case (s)
      0: return {1'b0, m_en};
      1: return {1'b0, m_pol};
      2: return {m_ast, 1'b0};
      default: return {m_dea, 1'b0};
    endcase
  endfunction

  task automatic check(input string tag, input logic [NP:0] act, input logic [NP:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s);
      #1;
      check((s < 2) ? "R10 model reg" : "R3/R4 model pending", rd_data, model_rd(s));
    end
    check("R7 model irq_assert", {31'd0, irq_a}, {31'd0, |(m_ast & m_en)});
    check("R7 model irq_deassert", {31'd0, irq_d}, {31'd0, |(m_dea & m_en)});
  endtask

  task automatic cyc(input logic [NP-1:0] p, input logic we, input logic [1:0] s,
                     input logic [NP:0] d);
    @(negedge clk);
    compare_all();
    pins = p; wr_en = we; wr_sel = s; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(pins, 1'b0, 2'd0, '0);
  endtask

  task automatic peek(input logic [1:0] s, input logic [NP:0] exp, input string tag);
    rd_sel = s;
    #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    // R1 reset state
    peek(2'd0, '0, "R1 enable after reset");
    peek(2'd2, '0, "R1 assert after reset");
    peek(2'd3, '0, "R1 deassert after reset");
    check("R1 irqs after reset", {30'd0, irq_a, irq_d}, '0);

    cyc(pins, 1'b1, 2'd0, 32'hFFFF_FFFF);
    peek(2'd0, 32'h7FFF_FFFF, "R10 enable readback bit31 zero");
    cyc(pins, 1'b1, 2'd1, 32'h0000_FFFF);
    peek(2'd1, 32'h0000_FFFF, "R10 polarity readback");

    // R9 latency, R3 rising edge with polarity 1 on pin 0
    cyc(pins | 31'h1, 1'b0, 2'd0, '0);
    peek(2'd2, '0, "R9 no event after edge 1");
    idle(1);
    peek(2'd2, '0, "R9 no event after edge 2");
    idle(1);
    peek(2'd2, 32'h2, "R9 R3 event after edge 3");
    peek(2'd3, '0, "R3 rise leaves deassert clear");
    check("R7 irq_assert with pin0 enabled", {31'd0, irq_a}, 32'd1);

    cyc(pins & ~31'h1, 1'b0, 2'd0, '0);
    idle(2);
    peek(2'd3, 32'h2, "R3 fall sets deassert pin0");

    // R4 polarity 0 on pin 20
    cyc(pins | (31'h1 << 20), 1'b0, 2'd0, '0);
    idle(2);
    peek(2'd3, 32'h2 | (32'h1 << 21), "R4 rise sets deassert pin20");
    peek(2'd2, 32'h2, "R4 rise leaves assert");
    cyc(pins & ~(31'h1 << 20), 1'b0, 2'd0, '0);
    idle(2);
    peek(2'd2, 32'h2 | (32'h1 << 21), "R4 fall sets assert pin20");

    // R5 clear pin0 only
    cyc(pins, 1'b1, 2'd2, 32'h2);
    peek(2'd2, 32'h1 << 21, "R5 clear keeps other bits");
    // R6 set pin4 in deassert, R2 bit0 reads zero
    cyc(pins, 1'b1, 2'd3, 32'h1 | (32'h1 << 5));
    peek(2'd3, 32'h2 | (32'h1 << 5) | (32'h1 << 21), "R6 R2 set write pin4 at bit5");

    // R7 enable gating
    cyc(pins, 1'b1, 2'd0, 32'h0);
    check("R7 irqs low with enables clear", {30'd0, irq_a, irq_d}, '0);
    cyc(pins, 1'b1, 2'd0, 32'h10);
    check("R7 R2 pin4 enable raises deassert irq only", {30'd0, irq_a, irq_d}, 32'h1);

    // R8 event versus same-cycle clear on pin 1 (polarity 1)
    cyc(pins, 1'b1, 2'd2, 32'h1 | 32'h4);
    cyc(pins | 31'h2, 1'b0, 2'd0, '0);
    idle(1);
    cyc(pins, 1'b1, 2'd2, 32'h4);
    peek(2'd2, 32'h4 | (32'h1 << 21), "R8 event wins over clear");

    // mixed stimulus against the model
    for (int i = 0; i < 400; i++) begin
      logic [NP-1:0] p;
      logic we;
      p = ($urandom % 3 == 0) ? NP'($urandom) : pins;
      we = ($urandom % 4 == 0);
      cyc(p, we, 2'($urandom), {$urandom} [NP:0]);
    end
    idle(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule